// File: doc/BRIEF.md
# Direction-Partitioned Reconfigurable Logic Cluster

This block is one tile of a reconfigurable fabric. It holds four small function units, each tied to one compass direction (north, east, south, west). Every unit is a 4-input lookup table whose result either passes straight out or goes through an output flip-flop. The four table inputs of a unit are chosen by multiplexers. A unit can see, combinationally, only the input bits that arrive from its own direction. It can see the other units' results only through their flip-flops. Tiles chained in one direction therefore form an acyclic path. Any change of direction adds a register, so no bitstream can build a combinational loop. All routing is done by multiplexers, so no bitstream can cause drive contention. An undefined select code yields a constant zero.

Configuration lives in two separate serial chains: one for the logic (table contents and bypass bits) and one for the routing (select codes). Each chain fills a shadow plane while the active plane keeps running. A single commit strobe moves both shadow planes into the active planes on one clock edge. Shadow contents survive a commit, so one chain can be reloaded and committed without touching the other. The chains accept one bit on every enabled cycle. There is no back-pressure, so plain enable pins are used instead of a handshake. A capture strobe takes a snapshot of the four unit flip-flops. The snapshot then shifts out one bit at a time while the fabric keeps working.

Top module: `lcluster_top`

## Requirements
- R1: After reset all configuration planes, unit flip-flops and the readback register are zero, so `dir_out` and `rb_dout` read 0.
- R2: Each unit output equals table bit `{i3,i2,i1,i0}`, where `i0`..`i3` are its routed inputs. With its bypass bit at 1 the output follows the inputs in the same cycle. With bypass at 0 the output is the flip-flop, which shows the table result one clock later.
- R3: Select codes 0..IN_W-1 pick bit `code` of the unit's own direction slice `dir_in[d*IN_W +: IN_W]` (N=0, E=1, S=2, W=3). A unit's output never reacts combinationally to another direction's input.
- R4: Select codes IN_W..IN_W+3 pick the flip-flop of unit N, E, S or W respectively, so a path that changes direction passes a register. Any larger code (6 and 7 with the default width of 3 bits) yields 0.
- R5: Shifting either chain (bits enter at the top and move toward bit 0, so the first bit shifted lands in bit 0 after a full load) leaves the active planes and the outputs unchanged until a commit.
- R6: A one-cycle `cfg_commit` makes both shadow planes active on that clock edge. A bypassed output shows the new function at the next sample.
- R7: Shadow planes keep their contents across a commit, so reloading only one chain and committing leaves the other plane's function in force.
- R8: Logic plane layout: unit u uses bits `[u*17 +: 16]` for its table and bit `u*17+16` for bypass. Routing plane layout: unit u, input k uses the 3 bits at `(u*4+k)*3`.
- R9: `rb_capture` copies the four unit flip-flops into the readback register. Each `rb_shift` then moves it one place so that `rb_dout` presents N, E, S, W in turn, then 0. Readback never alters `dir_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_in | input | 4*IN_W | Input bits per direction, slice d = N,E,S,W |
| dir_out | output | 4 | Unit outputs, bit d = N,E,S,W |
| lcfg_shift | input | 1 | Shift enable, logic chain |
| lcfg_din | input | 1 | Serial data, logic chain |
| rcfg_shift | input | 1 | Shift enable, routing chain |
| rcfg_din | input | 1 | Serial data, routing chain |
| cfg_commit | input | 1 | Copy both shadow planes to the active planes |
| rb_capture | input | 1 | Snapshot the unit flip-flops |
| rb_shift | input | 1 | Advance the readback register |
| rb_dout | output | 1 | Serial readback bit |

## Verification
The AND and XOR functions on the bypassed north and east units are swept through all four input combinations. This separates the table lookup from its index order, while the south and west inputs vary without effect. The south unit is stepped through edges to show the one-cycle delay of the registered path. The west unit reads the north flip-flop, and a north step must reach it exactly two samples later, which separates a cross-direction register path from a combinational one. Loading without commit, reloading one chain alone, using an undefined select code, and reading back a known flip-flop pattern while watching `dir_out` tell apart the shadow, commit, retention, zero-code and non-disturbing readback rules.

// File: rtl/lcluster_pkg.sv
package lcluster_pkg;
  localparam int N_DIR    = 4;
  localparam int LUT_K    = 4;
  localparam int LUT_BITS = 1 << LUT_K;
  localparam int UNIT_LW  = LUT_BITS + 1;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } dir_e;
endpackage

// File: rtl/lcluster_cfg_plane.sv
module lcluster_cfg_plane #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             din,
  input  logic             commit,
  output logic [WIDTH-1:0] shadow,
  output logic [WIDTH-1:0] active
);
  // shadow chain: new bits enter at the top, move toward bit 0
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (shift) begin
      shadow <= {din, shadow[WIDTH-1:1]};
    end
  end

  // active plane only changes on commit; shadow is kept
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
    end else if (commit) begin
      active <= shadow;
    end
  end
endmodule

// File: rtl/lcluster_func_unit.sv
module lcluster_func_unit
  import lcluster_pkg::*;
#(
  parameter int IN_W  = 2,
  parameter int SEL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IN_W-1:0]        local_in,
  input  logic [N_DIR-1:0]       unit_q,
  input  logic [LUT_BITS-1:0]    lut_cfg,
  input  logic                   bypass,
  input  logic [LUT_K*SEL_W-1:0] sel,
  output logic                   q,
  output logic                   out
);
  logic [LUT_K-1:0] lut_idx;
  logic             lut_out;

  // select: own-direction bits, then registered unit outputs, else zero
  always_comb begin
    for (int k = 0; k < LUT_K; k++) begin
      lut_idx[k] = 1'b0;
      for (int s = 0; s < IN_W; s++) begin
        if (int'(sel[k*SEL_W +: SEL_W]) == s) lut_idx[k] = local_in[s];
      end
      for (int s = 0; s < N_DIR; s++) begin
        if (int'(sel[k*SEL_W +: SEL_W]) == IN_W + s) lut_idx[k] = unit_q[s];
      end
    end
  end

  assign lut_out = lut_cfg[lut_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= lut_out;
  end

  // bypass reaches only this unit's own direction output
  assign out = bypass ? lut_out : q;
endmodule

// File: rtl/lcluster_readback.sv
module lcluster_readback #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         shift,
  input  logic [N-1:0] snap,
  output logic         dout
);
  logic [N-1:0] rb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_q <= '0;
    end else if (capture) begin
      rb_q <= snap;
    end else if (shift) begin
      rb_q <= {1'b0, rb_q[N-1:1]};
    end
  end

  assign dout = rb_q[0];
endmodule

// File: rtl/lcluster_top.sv
module lcluster_top
  import lcluster_pkg::*;
#(
  parameter int IN_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_DIR*IN_W-1:0] dir_in,
  output logic [N_DIR-1:0]      dir_out,
  input  logic                  lcfg_shift,
  input  logic                  lcfg_din,
  input  logic                  rcfg_shift,
  input  logic                  rcfg_din,
  input  logic                  cfg_commit,
  input  logic                  rb_capture,
  input  logic                  rb_shift,
  output logic                  rb_dout
);
  localparam int SEL_W   = $clog2(IN_W + N_DIR + 1);
  localparam int LOGIC_W = N_DIR * UNIT_LW;
  localparam int ROUTE_W = N_DIR * LUT_K * SEL_W;

  logic [LOGIC_W-1:0] logic_shadow, logic_active;
  logic [ROUTE_W-1:0] route_shadow, route_active;
  logic [N_DIR-1:0]   unit_q;

  lcluster_cfg_plane #(.WIDTH(LOGIC_W)) u_logic_plane (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift  (lcfg_shift),
    .din    (lcfg_din),
    .commit (cfg_commit),
    .shadow (logic_shadow),
    .active (logic_active)
  );

  lcluster_cfg_plane #(.WIDTH(ROUTE_W)) u_route_plane (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift  (rcfg_shift),
    .din    (rcfg_din),
    .commit (cfg_commit),
    .shadow (route_shadow),
    .active (route_active)
  );

  for (genvar d = 0; d < N_DIR; d++) begin : g_unit
    lcluster_func_unit #(.IN_W(IN_W), .SEL_W(SEL_W)) u_fu (
      .clk      (clk),
      .rst_n    (rst_n),
      .local_in (dir_in[d*IN_W +: IN_W]),
      .unit_q   (unit_q),
      .lut_cfg  (logic_active[d*UNIT_LW +: LUT_BITS]),
      .bypass   (logic_active[d*UNIT_LW + LUT_BITS]),
      .sel      (route_active[d*LUT_K*SEL_W +: LUT_K*SEL_W]),
      .q        (unit_q[d]),
      .out      (dir_out[d])
    );
  end

  lcluster_readback #(.N(N_DIR)) u_readback (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (rb_capture),
    .shift   (rb_shift),
    .snap    (unit_q),
    .dout    (rb_dout)
  );
endmodule

// File: rtl/lcluster_chk.sv
module lcluster_chk #(
  parameter int IN_W    = 2,
  parameter int LOGIC_W = 68,
  parameter int ROUTE_W = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_commit,
  input logic [4*IN_W-1:0]  dir_in,
  input logic [3:0]         dir_out,
  input logic [3:0]         unit_q,
  input logic [LOGIC_W-1:0] logic_shadow,
  input logic [LOGIC_W-1:0] logic_active,
  input logic [ROUTE_W-1:0] route_shadow,
  input logic [ROUTE_W-1:0] route_active,
  input logic               rb_capture,
  input logic               rb_shift,
  input logic               rb_dout
);
  assert_hold_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> ($stable(logic_active) && $stable(route_active)));

  assert_commit_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |=> ((logic_active == $past(logic_shadow)) &&
                    (route_active == $past(route_shadow))));

  assert_capture_north_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rb_capture |=> (rb_dout == $past(unit_q[0])));

  assert_rb_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_capture && !rb_shift) |=> $stable(rb_dout));

  for (genvar d = 0; d < 4; d++) begin : g_iso
    assert_dir_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(dir_in[d*IN_W +: IN_W]) && $stable(unit_q) &&
       $stable(logic_active) && $stable(route_active)) |-> $stable(dir_out[d]));
  end
endmodule

bind lcluster_top lcluster_chk #(
  .IN_W(IN_W), .LOGIC_W(LOGIC_W), .ROUTE_W(ROUTE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_commit   (cfg_commit),
  .dir_in       (dir_in),
  .dir_out      (dir_out),
  .unit_q       (unit_q),
  .logic_shadow (logic_shadow),
  .logic_active (logic_active),
  .route_shadow (route_shadow),
  .route_active (route_active),
  .rb_capture   (rb_capture),
  .rb_shift     (rb_shift),
  .rb_dout      (rb_dout)
);

// File: tb/lcluster_top_tb.sv
module lcluster_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 2;
  localparam int LW = 68;
  localparam int RW = 48;

  logic clk = 0, rst_n = 0;
  logic [4*IN_W-1:0] dir_in = '0;
  logic [3:0] dir_out;
  logic lcfg_shift = 0, lcfg_din = 0, rcfg_shift = 0, rcfg_din = 0;
  logic cfg_commit = 0, rb_capture = 0, rb_shift = 0, rb_dout;

  int cyc = 0, n_checks = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    int         due;
    int         sig;   // 0: dir_out, 1: rb_dout
    logic [3:0] exp;
    logic [3:0] mask;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcluster_top #(.IN_W(IN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .dir_out(dir_out),
    .lcfg_shift(lcfg_shift), .lcfg_din(lcfg_din),
    .rcfg_shift(rcfg_shift), .rcfg_din(rcfg_din),
    .cfg_commit(cfg_commit), .rb_capture(rb_capture),
    .rb_shift(rb_shift), .rb_dout(rb_dout)
  );

  // monitor: compare due scoreboard entries just after each falling edge
  always @(negedge clk) begin
    #1;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due <= cyc) begin
        logic [3:0] act;
        act = (sb[i].sig == 0) ? dir_out : {3'b000, rb_dout};
        n_checks++;
        if ((act & sb[i].mask) !== (sb[i].exp & sb[i].mask)) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b (mask %b)", sb[i].tag,
                   act & sb[i].mask, sb[i].exp & sb[i].mask, sb[i].mask);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_out(int dly, string tag, logic [3:0] e, logic [3:0] m);
    item_t it;
    it.tag = tag; it.due = cyc + dly; it.sig = 0; it.exp = e; it.mask = m;
    sb.push_back(it);
  endtask

  task automatic expect_rb(int dly, string tag, logic e);
    item_t it;
    it.tag = tag; it.due = cyc + dly; it.sig = 1; it.exp = {3'b000, e}; it.mask = 4'b0001;
    sb.push_back(it);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [16:0] lunit(logic [15:0] lut, logic byp);
    return {byp, lut};
  endfunction

  function automatic logic [11:0] runit(logic [2:0] s0, logic [2:0] s1, logic [2:0] s2, logic [2:0] s3);
    return {s3, s2, s1, s0};
  endfunction

  task automatic load_logic(logic [LW-1:0] v);
    for (int i = 0; i < LW; i++) begin
      lcfg_din = v[i]; lcfg_shift = 1; @(negedge clk);
    end
    lcfg_shift = 0;
  endtask

  task automatic load_route(logic [RW-1:0] v);
    for (int i = 0; i < RW; i++) begin
      rcfg_din = v[i]; rcfg_shift = 1; @(negedge clk);
    end
    rcfg_shift = 0;
  endtask

  task automatic commit();
    cfg_commit = 1; @(negedge clk); cfg_commit = 0;
  endtask

  function automatic logic [7:0] pins(logic [1:0] n, logic [1:0] e, logic [1:0] s, logic [1:0] w);
    return {w, s, e, n};
  endfunction

  logic [LW-1:0] cfg_a, cfg_b;
  logic [RW-1:0] rte_a, rte_b;

  initial begin
    // N: AND bypass, E: XOR bypass, S: OR registered, W: buffer of q_N registered
    cfg_a = {lunit(16'h0002, 0), lunit(16'h000E, 0), lunit(16'h0006, 1), lunit(16'h0008, 1)};
    cfg_b = {lunit(16'h0002, 0), lunit(16'h000E, 0), lunit(16'h0006, 1), lunit(16'h000E, 1)};
    rte_a = {runit(3'd2, 3'd6, 3'd6, 3'd6), runit(3'd0, 3'd1, 3'd6, 3'd6),
             runit(3'd0, 3'd1, 3'd6, 3'd6), runit(3'd0, 3'd1, 3'd6, 3'd6)};
    rte_b = {runit(3'd2, 3'd6, 3'd6, 3'd6), runit(3'd0, 3'd1, 3'd6, 3'd6),
             runit(3'd7, 3'd1, 3'd6, 3'd6), runit(3'd0, 3'd1, 3'd6, 3'd6)};

    step(3);
    rst_n = 1;
    expect_out(0, "R1 reset outputs", 4'b0000, 4'b1111);
    expect_rb(0, "R1 reset readback", 1'b0);

    // R5/R8: fill shadows with inputs active; outputs must stay at zero
    dir_in = pins(2'b11, 2'b01, 2'b11, 2'b11);
    load_logic(cfg_a);
    load_route(rte_a);
    expect_out(0, "R5 shadow load no effect", 4'b0000, 4'b1111);
    step(1);

    // R6: commit, bypassed units change on the next sample
    commit();
    expect_out(0, "R6 bypass units after commit", 4'b0011, 4'b0011);
    expect_out(0, "R2 registered S still old", 4'b0000, 4'b0100);
    expect_out(1, "R2 registered S one cycle later", 4'b0100, 4'b0100);
    step(3);

    // R2/R3: sweep N and E combinations, other directions vary freely
    for (int p = 0; p < 4; p++) begin
      dir_in = pins(p[1:0], p[1:0], 2'(3 - p), 2'(p + 1));
      expect_out(0, "R2 R3 N AND / E XOR sweep",
                 {2'b00, (p == 1 || p == 2), (p == 3)}, 4'b0011);
      step(1);
    end

    // R2: registered S path edges
    dir_in = pins(2'b00, 2'b00, 2'b01, 2'b00);
    step(2);
    dir_in = pins(2'b00, 2'b00, 2'b00, 2'b00);
    expect_out(0, "R2 S holds before edge", 4'b0100, 4'b0100);
    expect_out(1, "R2 S falls after edge", 4'b0000, 4'b0100);
    step(3);

    // R4: west reads q_N, so a north step needs two samples
    dir_in = pins(2'b11, 2'b00, 2'b00, 2'b00);
    expect_out(0, "R4 W unchanged same cycle", 4'b0000, 4'b1000);
    expect_out(1, "R4 W unchanged one cycle", 4'b0000, 4'b1000);
    expect_out(2, "R4 W after register path", 4'b1000, 4'b1000);
    step(3);

    // R7/R4: reload routing only, E input 0 uses undefined code 7
    load_route(rte_b);
    commit();
    dir_in = pins(2'b11, 2'b01, 2'b00, 2'b00);
    expect_out(0, "R4 zero code with in_e=01", 4'b0000, 4'b0010);
    expect_out(0, "R7 logic kept after route reload", 4'b0001, 4'b0001);
    step(1);
    dir_in = pins(2'b11, 2'b11, 2'b00, 2'b00);
    expect_out(0, "R4 zero code with in_e=11", 4'b0010, 4'b0010);
    step(1);

    // R7: reload logic only, N becomes OR; routing from previous commit kept
    load_logic(cfg_b);
    commit();
    dir_in = pins(2'b01, 2'b01, 2'b01, 2'b00);
    expect_out(0, "R7 N OR after logic reload", 4'b0001, 4'b0001);
    expect_out(0, "R7 routing kept after logic reload", 4'b0000, 4'b0010);
    step(4);

    // R9: q = {W=1,S=1,E=0,N=1}; read back without disturbing outputs
    expect_out(0, "R9 outputs before capture", 4'b1101, 4'b1111);
    rb_capture = 1; step(1); rb_capture = 0;
    expect_rb(0, "R9 readback N", 1'b1);
    expect_out(0, "R9 outputs during readback", 4'b1101, 4'b1111);
    rb_shift = 1; step(1);
    expect_rb(0, "R9 readback E", 1'b0);
    step(1);
    expect_rb(0, "R9 readback S", 1'b1);
    expect_out(0, "R9 outputs during shift", 4'b1101, 4'b1111);
    step(1);
    expect_rb(0, "R9 readback W", 1'b1);
    step(1);
    rb_shift = 0;
    expect_rb(0, "R9 readback emptied", 1'b0);
    expect_out(0, "R9 outputs after readback", 4'b1101, 4'b1111);
    step(3);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule